// File: doc/BRIEF.md
# Multi-Mode Bidirectional Port Controller

This block controls one 8-bit bidirectional port on a microcontroller peripheral bus. It holds a per-pin direction register and an output data register. From these, and from a set of mode controls, it drives one output-enable and one output-value signal per pin. Reads at the direction register's address do not return the stored direction bits. They return the live level on the pins.

Each pin's function is selected by the operating mode, an external-expansion flag, an address-override bit and a keyboard-enable bit.

- In single-chip operation, a pin whose direction bit is set drives the output data register.
- In expanded operation, a pin whose direction bit is set drives the matching bit of an address bus instead. The override bit returns such pins to the output data register.
- When the keyboard-enable bit is set, the upper six pins are handed to an external keyboard controller and their direction bits are ignored. The two lowest pins keep their port behaviour.

Top module: `gpio_port`

## Requirements
- R1: After reset, both the direction register and the output data register are zero. With keyboard-enable clear, every `pin_oe` and `pin_out` bit is 0, and a read of the output data register (address 1) returns 0.
- R2: The direction register (address 0) is write-only. A read at address 0 returns `pin_in` combinationally, whatever has been written there.
- R3: Single-chip operation is every `op_mode` value other than 2, or `op_mode` = 2 with `ext_bus_en` = 0. In single-chip operation, a pin whose direction bit is 1 has `pin_oe` = 1 and drives its output-data bit.
- R4: A pin whose direction bit is 0, and which is not handed to the keyboard controller, has `pin_oe` = 0 and `pin_out` = 0.
- R5: With `op_mode` = 2, `ext_bus_en` = 1 and `addr_override` = 0, a pin whose direction bit is 1 has `pin_oe` = 1 and drives the same bit of `exp_addr`.
- R6: With `op_mode` = 2, `ext_bus_en` = 1 and `addr_override` = 1, a pin whose direction bit is 1 drives its output-data bit instead of the address bit.
- R7: With `kbd_en` = 1, pins 7..2 take `pin_oe` and `pin_out` from `kbd_oe` and `kbd_out` (bit 0 of those vectors belongs to pin 2) in every mode, whatever their direction bits hold. `kbd_in` always mirrors `pin_in[7:2]`.
- R8: Pins 1 and 0 behave as in R3 to R6 whatever the value of `kbd_en`.
- R9: The output data register (address 1) can be written and read back with any value, whatever the direction register holds.
- R10: Reads at addresses 2 and 3 return 0. Writes to addresses 2 and 3 change neither register.
- R11: A write with `bus_wr` = 1 takes effect at the rising clock edge where the strobe is sampled. Pin outputs show the new value from that edge onward and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| op_mode | input | 2 | Operating mode; value 2 allows expanded operation |
| ext_bus_en | input | 1 | External-expansion flag |
| addr_override | input | 1 | Expanded-mode override that returns output pins to the output data register |
| kbd_en | input | 1 | Hands pins 7..2 to the keyboard controller |
| exp_addr | input | 8 | Address bus bits for expanded operation |
| kbd_out | input | 6 | Keyboard controller output values for pins 7..2 |
| kbd_oe | input | 6 | Keyboard controller output enables for pins 7..2 |
| kbd_in | output | 6 | Pin levels of pins 7..2 for the keyboard controller |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
A wrong stored direction bit shows on `pin_oe` in the cycle after the write that set it, for every pin not handed to the keyboard controller. A corrupt output data bit shows both on the pin and on a read of address 1 in that same cycle. A wrong source choice per pin, such as address instead of output data or port instead of keyboard, is purely combinational and shows on `pin_out` as soon as the controls change. The bench therefore sweeps every combination of mode, expansion, override and keyboard-enable against several direction patterns and checks every pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SRC_INPUT = 2'd0,
    SRC_PORT  = 2'd1,
    SRC_ADDR  = 2'd2,
    SRC_KBD   = 2'd3
  } pin_src_e;

  localparam logic [1:0] MODE_EXPANDABLE = 2'd2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int          WIDTH     = 8,
  parameter int          ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 0,
  parameter logic [ADDR_W-1:0] ODR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  odr_q
);
  logic             dir_en, odr_en;
  logic [WIDTH-1:0] dir_d, odr_d;

  always_comb begin
    dir_en = bus_wr && (bus_addr == DIR_ADDR);
    odr_en = bus_wr && (bus_addr == ODR_ADDR);
    dir_d  = bus_wdata;
    odr_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      odr_q <= '0;
    else if (odr_en) odr_q <= odr_d;
  end

  always_comb begin
    if (bus_addr == DIR_ADDR)      bus_rdata = pin_in;
    else if (bus_addr == ODR_ADDR) bus_rdata = odr_q;
    else                           bus_rdata = '0;
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int KBD_LO = 2,
  localparam int KBD_W = WIDTH - KBD_LO
) (
  input  logic [1:0]       op_mode,
  input  logic             ext_bus_en,
  input  logic             addr_override,
  input  logic             kbd_en,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] odr_q,
  input  logic [WIDTH-1:0] exp_addr,
  input  logic [KBD_W-1:0] kbd_out,
  input  logic [KBD_W-1:0] kbd_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic addr_drive;

  always_comb begin
    addr_drive = (op_mode == MODE_EXPANDABLE) && ext_bus_en && !addr_override;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_src_e src;
    logic     kbd_o, kbd_e;

    if (i >= KBD_LO) begin : g_kbd
      always_comb begin
        kbd_o = kbd_out[i-KBD_LO];
        kbd_e = kbd_oe[i-KBD_LO];
      end
    end else begin : g_plain
      always_comb begin
        kbd_o = 1'b0;
        kbd_e = 1'b0;
      end
    end

    always_comb begin
      if (kbd_en && (i >= KBD_LO)) src = SRC_KBD;
      else if (!dir_q[i])          src = SRC_INPUT;
      else if (addr_drive)         src = SRC_ADDR;
      else                         src = SRC_PORT;
    end

    always_comb begin
      unique case (src)
        SRC_KBD:  begin pin_oe[i] = kbd_e; pin_out[i] = kbd_o;       end
        SRC_ADDR: begin pin_oe[i] = 1'b1;  pin_out[i] = exp_addr[i]; end
        SRC_PORT: begin pin_oe[i] = 1'b1;  pin_out[i] = odr_q[i];    end
        default:  begin pin_oe[i] = 1'b0;  pin_out[i] = 1'b0;        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2,
  parameter int KBD_LO = 2,
  localparam int KBD_W = WIDTH - KBD_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [1:0]        op_mode,
  input  logic              ext_bus_en,
  input  logic              addr_override,
  input  logic              kbd_en,
  input  logic [WIDTH-1:0]  exp_addr,
  input  logic [KBD_W-1:0]  kbd_out,
  input  logic [KBD_W-1:0]  kbd_oe,
  output logic [KBD_W-1:0]  kbd_in,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] dir_q, odr_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .DIR_ADDR(ADDR_W'(0)), .ODR_ADDR(ADDR_W'(1))
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .pin_in(pin_in), .bus_rdata(bus_rdata),
    .dir_q(dir_q), .odr_q(odr_q)
  );

  gpio_pinmux #(.WIDTH(WIDTH), .KBD_LO(KBD_LO)) u_mux (
    .op_mode(op_mode), .ext_bus_en(ext_bus_en),
    .addr_override(addr_override), .kbd_en(kbd_en),
    .dir_q(dir_q), .odr_q(odr_q), .exp_addr(exp_addr),
    .kbd_out(kbd_out), .kbd_oe(kbd_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign kbd_in = pin_in[WIDTH-1:KBD_LO];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2,
  parameter int KBD_LO = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic              kbd_en,
  input logic [WIDTH-KBD_LO-1:0] kbd_oe,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  odr_q
);
  AST_RD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata == pin_in)); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (dir_q == $past(bus_wdata))); // R11
  AST_ODR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> (odr_q == $past(bus_wdata))); // R9
  AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > ADDR_W'(1)) |=> ($stable(dir_q) && $stable(odr_q))); // R10
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(1)) |-> (bus_rdata == '0)); // R10
  AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe[KBD_LO-1:0] & ~dir_q[KBD_LO-1:0]) == '0)); // R4
  AST_KBD_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_en |-> (pin_oe[WIDTH-1:KBD_LO] == kbd_oe)); // R7
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .KBD_LO(KBD_LO)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_en(kbd_en),
  .kbd_oe(kbd_oe), .pin_in(pin_in), .pin_oe(pin_oe),
  .dir_q(dir_q), .odr_q(odr_q)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] op_mode = 1;
  logic       ext_bus_en = 0, addr_override = 0, kbd_en = 0;
  logic [7:0] exp_addr = 0;
  logic [5:0] kbd_out = 0, kbd_oe = 0, kbd_in;
  logic [7:0] pin_in = 0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_mode(op_mode),
    .ext_bus_en(ext_bus_en), .addr_override(addr_override), .kbd_en(kbd_en),
    .exp_addr(exp_addr), .kbd_out(kbd_out), .kbd_oe(kbd_oe), .kbd_in(kbd_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] model(input logic [7:0] dir, input logic [7:0] odr);
    logic [7:0] oe, o;
    logic adr;
    adr = (op_mode == 2'd2) && ext_bus_en && !addr_override;
    for (int i = 0; i < 8; i++) begin
      if (kbd_en && i >= 2)  begin oe[i] = kbd_oe[i-2]; o[i] = kbd_out[i-2]; end
      else if (!dir[i])      begin oe[i] = 0; o[i] = 0; end
      else if (adr)          begin oe[i] = 1; o[i] = exp_addr[i]; end
      else                   begin oe[i] = 1; o[i] = odr[i]; end
    end
    return {oe, o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] dirs [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 oe", {8'h0, pin_oe}, 16'h0);
    check("R1 out", {8'h0, pin_out}, 16'h0);
    rd(2'd1, d); check("R1 odr", {8'h0, d}, 16'h0);

    // R2: address 0 returns pins
    foreach (dirs[k]) begin
      pin_in = dirs[k] ^ 8'h5A;
      rd(2'd0, d); check("R2 pins", {8'h0, d}, {8'h0, pin_in});
    end
    wr(2'd0, 8'hFF);
    pin_in = 8'h12;
    rd(2'd0, d); check("R2 after dir write", {8'h0, d}, 16'h0012);

    // R9: output data register round trip regardless of direction
    for (int v = 0; v < 256; v += 17) begin
      wr(2'd0, 8'(v * 3));
      wr(2'd1, 8'(v));
      rd(2'd1, d); check("R9 odr readback", {8'h0, d}, {8'h0, 8'(v)});
    end

    // R3..R8 sweep
    exp_addr = 8'h96; kbd_out = 6'h2B; kbd_oe = 6'h15;
    foreach (dirs[k]) begin
      logic [7:0] odr;
      odr = ~dirs[k] ^ 8'h0F;
      wr(2'd0, dirs[k]);
      wr(2'd1, odr);
      for (int c = 0; c < 32; c++) begin
        logic [15:0] e;
        string tag;
        @(negedge clk);
        op_mode = c[1:0]; ext_bus_en = c[2]; addr_override = c[3]; kbd_en = c[4];
        #1 e = model(dirs[k], odr);
        if (op_mode == 2'd2 && ext_bus_en) tag = addr_override ? "R6" : "R5";
        else tag = "R3";
        if (dirs[k] == 8'h00) tag = "R4";
        if (kbd_en) check("R7 upper pins", {2'b0, pin_oe[7:2], 2'b0, pin_out[7:2]},
                          {2'b0, e[15:10], 2'b0, e[7:2]});
        else check({tag, " upper pins"}, {2'b0, pin_oe[7:2], 2'b0, pin_out[7:2]},
                   {2'b0, e[15:10], 2'b0, e[7:2]});
        check(kbd_en ? "R8 low pins" : {tag, " low pins"},
              {6'b0, pin_oe[1:0], 6'b0, pin_out[1:0]}, {6'b0, e[9:8], 6'b0, e[1:0]});
      end
    end
    kbd_en = 0; op_mode = 1; ext_bus_en = 0; addr_override = 0;

    // R7: keyboard input mirror
    pin_in = 8'hC4; #1 check("R7 kbd_in", {10'h0, kbd_in}, 16'h0031);
    pin_in = 8'h3B; #1 check("R7 kbd_in", {10'h0, kbd_in}, 16'h000E);

    // R10: unmapped addresses
    wr(2'd0, 8'h0F); wr(2'd1, 8'h55);
    rd(2'd2, d); check("R10 rd 2", {8'h0, d}, 16'h0);
    rd(2'd3, d); check("R10 rd 3", {8'h0, d}, 16'h0);
    wr(2'd2, 8'hF0); wr(2'd3, 8'hAA);
    rd(2'd1, d); check("R10 odr kept", {8'h0, d}, 16'h0055);
    check("R10 dir kept", {8'h0, pin_oe}, 16'h000F);

    // R11: write visible from the sampling edge
    @(negedge clk);
    bus_addr = 2'd1; bus_wr = 1; bus_wdata = 8'hFA;
    #5 check("R11 before edge", {8'h0, pin_out}, 16'h0005);
    @(negedge clk);
    bus_wr = 0;
    check("R11 after edge", {8'h0, pin_out}, 16'h000A);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule